// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs one serial-flash transaction each time software asks for one. Software places a command word (an 8-bit opcode and a 24-bit flash address) and, when the command carries payload, a 32-bit data word into their registers. It then writes the control register with a transmit byte count, a receive byte count, a clock-select value and the go bit. The engine pulls chip select low and clocks out the requested bytes in SPI mode 0. It then clocks in the requested reply bytes without releasing chip select, and stores the reply in the data register.

A transmit count of 1 sends the opcode alone. A count of 4 adds three address bytes. Counts from 5 to 8 add payload bytes from the data register. A single go bit can therefore issue anything from a bare status command up to an eight-byte program frame. The register bus is a plain single-cycle 32-bit write/read port, and read data is returned one cycle after the read strobe.

Top module: `spi_cmd_engine`

## Requirements
- R1: Byte offset 0x0 is control and 0x4 is the command word. Offset 0x8 is data, and other offsets read as zero. Control fields: transmit count in bits 3:0, receive count in bits 7:4, go in bit 8 (always reads 0), busy in bit 16 (read-only), size in bits 18:17 (stored and read back only), and clock select in bits 25:24. Read data appears on `bus_rdata` in the cycle after `bus_rd_en`.
- R2: A control write with bit 8 set while idle starts a frame. In the next cycle busy reads 1 and `spi_cs_n` is low.
- R3: Outgoing bytes are sent in this order: command bits 7:0, then 31:24, 23:16 and 15:8, then data bits 7:0, 15:8, 23:16 and 31:24. Only the first transmit-count bytes are sent, each MSB first. `spi_mosi` is 0 outside the transmit bits.
- R4: SCLK idles low. MOSI changes only on falling edges (or when the frame starts) and holds steady across each rising edge. MISO is sampled on each rising edge.
- R5: Clock select values 0, 1, 2 and 3 give an SCLK half-period of 1, 2, 4 and 8 system clocks.
- R6: Chip select stays low for (16·(tx+rx)+1) half-periods. That is every bit plus one trailing half-period, and busy falls in the same cycle that chip select rises.
- R7: Received bytes are packed with the first byte in data bits 7:0, each byte MSB first. Bytes beyond the receive count read as zero. The data register is replaced at frame end only when the receive count is nonzero.
- R8: While busy, writes to every register are ignored, including a second go.
- R9: A go with both counts zero starts nothing: chip select stays high and busy stays 0.
- R10: A transmit count above 8 acts as 8, and a receive count above 4 acts as 4, while the raw values read back unchanged.
- R11: After reset all registers read zero, `spi_cs_n` is 1, and `spi_sclk` and `spi_mosi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd_en | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check several properties on every cycle. Pins are quiet whenever the engine is idle. SCLK toggles only inside a frame with chip select already low. MOSI never moves across a rising SCLK edge. The divider count stays inside the chosen half-period. Register contents stay frozen while busy, and busy never rises without a go write.

Other properties can only be shown by the bench scenarios. These include the byte order on the wire, the exact frame length for each clock select, how received bytes are packed and masked, count clamping, and the zero-length go case. The bench shows them by comparing the pins every cycle against a behavioural model and by reading the registers back.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h8;

  localparam int CNT_W  = 4;
  localparam int SEL_W  = 2;
  localparam int SIZE_W = 2;

  // Control word bit positions
  localparam int POS_TX   = 0;
  localparam int POS_RX   = 4;
  localparam int POS_GO   = 8;
  localparam int POS_BUSY = 16;
  localparam int POS_SIZE = 17;
  localparam int POS_SEL  = 24;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [SIZE_W-1:0] size;
    logic [CNT_W-1:0]  rx;
    logic [CNT_W-1:0]  tx;
  } ctrl_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SHIFT, PH_TAIL} phase_t;

  function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.tx   = w[POS_TX +: CNT_W];
    c.rx   = w[POS_RX +: CNT_W];
    c.size = w[POS_SIZE +: SIZE_W];
    c.sel  = w[POS_SEL +: SEL_W];
    return c;
  endfunction
endpackage

// File: rtl/spi_cmd_clkgen.sv
module spi_cmd_clkgen
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 1 << SEL_W;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (DIV_W'(1) << sel) - DIV_W'(1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

  // R5: the half-period counter never passes the selected limit
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= last));
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  input  logic              rx_valid,
  input  logic [REG_W-1:0]  rx_word,
  output logic              start_req,
  output ctrl_t             start_cfg,
  output logic [REG_W-1:0]  cmd_word,
  output logic [REG_W-1:0]  data_word,
  output logic [REG_W-1:0]  rdata
);
  ctrl_t            ctrl;
  logic             wr_ok;
  logic [REG_W-1:0] rd_mux;

  assign wr_ok     = wr_en && !busy;
  assign start_cfg = unpack_ctrl(wdata);
  assign start_req = wr_ok && (addr == OFS_CTRL) && wdata[POS_GO];

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CTRL: begin
        rd_mux[POS_TX +: CNT_W]    = ctrl.tx;
        rd_mux[POS_RX +: CNT_W]    = ctrl.rx;
        rd_mux[POS_SIZE +: SIZE_W] = ctrl.size;
        rd_mux[POS_SEL +: SEL_W]   = ctrl.sel;
        rd_mux[POS_BUSY]           = busy;
      end
      OFS_CMD:  rd_mux = cmd_word;
      OFS_DATA: rd_mux = data_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      cmd_word  <= '0;
      data_word <= '0;
      rdata     <= '0;
    end else begin
      if (wr_ok && addr == OFS_CTRL) ctrl <= start_cfg;
      if (wr_ok && addr == OFS_CMD)  cmd_word <= wdata;
      if (rx_valid)                          data_word <= rx_word;
      else if (wr_ok && addr == OFS_DATA) data_word <= wdata;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R8: register contents hold while a frame is in flight
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(cmd_word));
  a_r8_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(ctrl));
  a_r8_data_frozen: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(rx_valid)) |-> $stable(data_word));
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int MAX_TX_BYTES = 8,
  parameter int MAX_RX_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_req,
  input  ctrl_t                       start_cfg,
  input  logic [REG_W-1:0]            cmd_word,
  input  logic [REG_W-1:0]            data_word,
  input  logic                        tick,
  input  logic                        miso,
  output logic                        run,
  output logic [SEL_W-1:0]            sel,
  output logic                        busy,
  output logic                        cs_n,
  output logic                        sclk,
  output logic                        mosi,
  output logic                        rx_valid,
  output logic [MAX_RX_BYTES*8-1:0]   rx_word
);
  localparam int TXV_W = MAX_TX_BYTES * 8;
  localparam int RX_W  = MAX_RX_BYTES * 8;
  localparam int BIT_W = $clog2((MAX_TX_BYTES + MAX_RX_BYTES) * 8 + 1);
  localparam int RXI_W = $clog2(RX_W);

  phase_t             phase;
  logic [TXV_W-1:0]   tx_sh, frame;
  logic [BIT_W-1:0]   tx_bits, last_bit, bit_cnt, rx_idx;
  logic [RXI_W-1:0]   rx_pos;
  logic [CNT_W-1:0]   tx_n, rx_n;
  logic               rx_any, go;

  assign tx_n = (start_cfg.tx > CNT_W'(MAX_TX_BYTES)) ? CNT_W'(MAX_TX_BYTES) : start_cfg.tx;
  assign rx_n = (start_cfg.rx > CNT_W'(MAX_RX_BYTES)) ? CNT_W'(MAX_RX_BYTES) : start_cfg.rx;
  assign go   = start_req && ((tx_n != '0) || (rx_n != '0));

  // Outgoing frame: opcode, address high to low, then payload low to high
  always_comb begin
    frame = '0;
    for (int k = 0; k < MAX_TX_BYTES; k++) begin
      if (k == 0)     frame[TXV_W-1-8*k -: 8] = cmd_word[7:0];
      else if (k < 4) frame[TXV_W-1-8*k -: 8] = cmd_word[8*(4-k) +: 8];
      else            frame[TXV_W-1-8*k -: 8] = data_word[8*(k-4) +: 8];
    end
  end

  assign rx_idx   = bit_cnt - tx_bits;
  assign rx_pos   = {rx_idx[RXI_W-1:3], ~rx_idx[2:0]};
  assign run      = (phase != PH_IDLE);
  assign busy     = run;
  assign rx_valid = (phase == PH_TAIL) && tick && rx_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      tx_sh    <= '0;
      tx_bits  <= '0;
      last_bit <= '0;
      bit_cnt  <= '0;
      rx_any   <= 1'b0;
      rx_word  <= '0;
      sel      <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (go) begin
          phase    <= PH_SHIFT;
          cs_n     <= 1'b0;
          sclk     <= 1'b0;
          tx_sh    <= frame;
          mosi     <= (tx_n != '0) && frame[TXV_W-1];
          tx_bits  <= BIT_W'(tx_n) << 3;
          last_bit <= (BIT_W'(tx_n) + BIT_W'(rx_n)) * BIT_W'(8) - BIT_W'(1);
          bit_cnt  <= '0;
          rx_any   <= (rx_n != '0);
          rx_word  <= '0;
          sel      <= start_cfg.sel;
        end
        PH_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (bit_cnt >= tx_bits) rx_word[rx_pos] <= miso;
          end else begin
            sclk  <= 1'b0;
            tx_sh <= tx_sh << 1;
            if (bit_cnt == last_bit) begin
              phase <= PH_TAIL;
              mosi  <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + BIT_W'(1);
              mosi    <= ((bit_cnt + BIT_W'(1)) < tx_bits) && tx_sh[TXV_W-2];
            end
          end
        end
        PH_TAIL: if (tick) begin
          phase <= PH_IDLE;
          cs_n  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R11: pins are quiet when no frame is active
  a_r11_idle_pins: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk));
  // R4: MOSI does not move across a rising SCLK edge
  a_r4_mosi_held: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  // R4: SCLK toggles only inside a frame whose select was already low
  a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    (sclk != $past(sclk)) |-> (!cs_n && !$past(cs_n)));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int MAX_TX_BYTES = 8,
  parameter int MAX_RX_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr_en,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd_en,
  output logic [31:0] bus_rdata,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int RX_W = MAX_RX_BYTES * 8;

  logic             start_req, busy, run, tick, rx_valid;
  ctrl_t            start_cfg;
  logic [REG_W-1:0] cmd_word, data_word, rx_ext;
  logic [RX_W-1:0]  rx_word;
  logic [SEL_W-1:0] sel;

  assign rx_ext = REG_W'(rx_word);

  spi_cmd_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .wr_en     (bus_wr_en),
    .rd_en     (bus_rd_en),
    .wdata     (bus_wdata),
    .busy      (busy),
    .rx_valid  (rx_valid),
    .rx_word   (rx_ext),
    .start_req (start_req),
    .start_cfg (start_cfg),
    .cmd_word  (cmd_word),
    .data_word (data_word),
    .rdata     (bus_rdata)
  );

  spi_cmd_clkgen u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (sel),
    .tick (tick)
  );

  spi_cmd_shifter #(
    .MAX_TX_BYTES (MAX_TX_BYTES),
    .MAX_RX_BYTES (MAX_RX_BYTES)
  ) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .start_cfg (start_cfg),
    .cmd_word  (cmd_word),
    .data_word (data_word),
    .tick      (tick),
    .miso      (spi_miso),
    .run       (run),
    .sel       (sel),
    .busy      (busy),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word)
  );

  // R2: busy only rises in response to a go write on the control register
  a_r2_busy_after_go: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr_en && (bus_addr == OFS_CTRL) && bus_wdata[POS_GO]));
endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd_en = 1'b0;
  logic [31:0] bus_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_engine u_spi_cmd_engine (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_active;
  int          m_cnt, m_edge, m_half, m_nbits, m_tx, m_rx;
  logic [31:0] m_cmd, m_data, m_rxw;
  logic [63:0] m_frame;
  logic [3:0]  m_txr, m_rxr;
  logic [1:0]  m_size, m_sel;

  function automatic logic [63:0] bench_frame(input logic [31:0] c, input logic [31:0] d);
    return {c[7:0], c[31:8], d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [31:0] model_ctrl();
    return {6'b0, m_sel, 5'b0, m_size, m_active, 8'b0, m_rxr, m_txr};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; m_cnt = 0; m_edge = 0; m_half = 1; m_nbits = 0;
      m_tx = 0; m_rx = 0; m_cmd = 0; m_data = 0; m_rxw = 0; m_frame = 0;
      m_txr = 0; m_rxr = 0; m_size = 0; m_sel = 0;
    end else begin
      bit was;
      was = m_active;
      if (was) begin
        if (m_cnt == m_half - 1) begin
          m_cnt = 0;
          m_edge++;
          if (m_edge == 2 * m_nbits + 1) begin
            m_active = 0;
            if (m_rx > 0) m_data = m_rxw;
          end else if (m_edge % 2 == 1) begin
            int k, j;
            k = (m_edge - 1) / 2;
            if (k >= m_tx * 8) begin
              j = k - m_tx * 8;
              m_rxw[(j / 8) * 8 + 7 - (j % 8)] = spi_miso;
            end
          end
        end else m_cnt++;
      end
      if (bus_wr_en && !was) begin
        case (bus_addr)
          4'h0: begin
            m_txr = bus_wdata[3:0]; m_rxr = bus_wdata[7:4];
            m_size = bus_wdata[18:17]; m_sel = bus_wdata[25:24];
            if (bus_wdata[8]) begin
              m_tx = (m_txr > 8) ? 8 : int'(m_txr);
              m_rx = (m_rxr > 4) ? 4 : int'(m_rxr);
              if (m_tx + m_rx > 0) begin
                m_active = 1; m_cnt = 0; m_edge = 0;
                m_half = 1 << m_sel; m_nbits = (m_tx + m_rx) * 8;
                m_rxw = 0; m_frame = bench_frame(m_cmd, m_data);
              end
            end
          end
          4'h4: m_cmd = bus_wdata;
          4'h8: m_data = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // Per-cycle pin comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      int bi;
      logic exp_mosi;
      bi = m_edge / 2;
      exp_mosi = (m_active && bi < m_tx * 8) ? m_frame[63 - bi] : 1'b0;
      chk("R6 R2 spi_cs_n", {31'b0, spi_cs_n}, {31'b0, !m_active});
      chk("R4 R5 spi_sclk", {31'b0, spi_sclk}, {31'b0, m_active && (m_edge % 2 == 1)});
      chk("R3 spi_mosi", {31'b0, spi_mosi}, {31'b0, exp_mosi});
    end
  end

  // ---------------- flash-side responder ----------------
  logic [95:0] slave_stream = {12{8'hA5}};
  int rcnt = 0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (spi_cs_n) rcnt = 0;
    else if (spi_sclk && !prev_sclk) rcnt++;
    prev_sclk = spi_sclk;
    spi_miso = (rcnt < 96) ? slave_stream[95 - rcnt] : 1'b0;
  end

  task automatic slave_load(input int start_byte, input logic [31:0] reply);
    slave_stream = {12{8'hA5}};
    for (int i = 0; i < 4; i++)
      slave_stream[95 - 8 * (start_byte + i) -: 8] = reply[8*i +: 8];
  endtask

  // ---------------- bus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp_fixed, input bit use_model,
                    input string tag);
    logic [31:0] e;
    @(negedge clk);
    e = use_model ? model_ctrl() : exp_fixed;
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk(tag, bus_rdata, e);
  endtask

  function automatic logic [31:0] ctrl_word(input int tx, input int rx, input int sel,
                                            input int size, input bit go);
    return (32'(sel) << 24) | (32'(size) << 17) | (32'(go) << 8) | (32'(rx) << 4) | 32'(tx);
  endfunction

  // Start a frame and measure how many cycles chip select stays low
  task automatic run_frame(input int tx, input int rx, input int sel, input int exp_len,
                           input string tag);
    int n;
    wr(4'h0, ctrl_word(tx, rx, sel, 0, 1'b1));
    n = 0;
    while (!spi_cs_n) begin
      @(negedge clk);
      n++;
    end
    chk(tag, 32'(n), 32'(exp_len));
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 cs_n after reset", {31'b0, spi_cs_n}, 32'd1);
    rd(4'h0, 32'h0, 1'b0, "R11 control after reset");
    rd(4'h4, 32'h0, 1'b0, "R11 command after reset");
    rd(4'h8, 32'h0, 1'b0, "R11 data after reset");

    // R1 readback without go, unknown offset reads zero
    wr(4'h0, ctrl_word(3, 2, 1, 2, 1'b0));
    rd(4'h0, ctrl_word(3, 2, 1, 2, 1'b0), 1'b0, "R1 control readback, go reads 0");
    chk("R1 no frame without go", {31'b0, spi_cs_n}, 32'd1);
    wr(4'h4, 32'h00000006);
    rd(4'h4, 32'h00000006, 1'b0, "R1 command readback");
    rd(4'hC, 32'h0, 1'b0, "R1 unmapped offset");

    // R3 R5 R6 bare opcode, divide by 2
    run_frame(1, 0, 0, 17, "R6 R5 opcode-only frame length sel0");

    // R7 one reply byte after four command bytes, divide by 4
    wr(4'h4, 32'h000000AB);
    slave_load(4, 32'h66559917);
    run_frame(4, 1, 1, 162, "R6 R5 signature frame length sel1");
    rd(4'h8, 32'h00000017, 1'b0, "R7 single reply byte, upper bytes zero");

    // R3 eight-byte program frame, divide by 8; R2 busy visible mid-frame
    wr(4'h8, 32'hA1B2C3D4);
    wr(4'h4, 32'h12345602);
    wr(4'h0, ctrl_word(8, 0, 2, 0, 1'b1));
    rd(4'h0, 32'h0, 1'b1, "R2 busy set during frame");
    chk("R2 cs_n low during frame", {31'b0, spi_cs_n}, 32'd0);
    while (!spi_cs_n) @(negedge clk);
    rd(4'h8, 32'hA1B2C3D4, 1'b0, "R7 data kept when receive count is 0");

    // R8 writes during a frame are ignored; R7 four-byte packing, divide by 16
    wr(4'h4, 32'h00ABCD03);
    slave_load(4, 32'h44332211);
    wr(4'h0, ctrl_word(4, 4, 3, 0, 1'b1));
    repeat (20) @(negedge clk);
    wr(4'h0, ctrl_word(1, 0, 0, 0, 1'b1));
    wr(4'h4, 32'hDEADBEEF);
    wr(4'h8, 32'h12345678);
    while (!spi_cs_n) @(negedge clk);
    rd(4'h8, 32'h44332211, 1'b0, "R7 R8 four reply bytes packed, busy write dropped");
    rd(4'h4, 32'h00ABCD03, 1'b0, "R8 command unchanged by busy write");
    rd(4'h0, ctrl_word(4, 4, 3, 0, 1'b0), 1'b0, "R8 control unchanged by busy go");

    // R9 zero-length go
    wr(4'h0, ctrl_word(0, 0, 0, 0, 1'b1));
    repeat (5) @(negedge clk);
    chk("R9 zero-length go leaves cs_n high", {31'b0, spi_cs_n}, 32'd1);
    rd(4'h0, 32'h0, 1'b0, "R9 busy stays clear");

    // R10 clamping of oversized counts
    wr(4'h4, 32'h0F0E0D0C);
    wr(4'h8, 32'h55AA33CC);
    slave_load(8, 32'hF00F5AC3);
    run_frame(15, 15, 0, 193, "R10 clamped frame length");
    rd(4'h8, 32'hF00F5AC3, 1'b0, "R10 clamped reply of four bytes");
    rd(4'h0, ctrl_word(15, 15, 0, 0, 1'b0), 1'b0, "R10 raw counts read back");

    // R7 receive-only frame
    slave_load(0, 32'h1234EFBE);
    run_frame(0, 2, 1, 66, "R6 receive-only frame length");
    rd(4'h8, 32'h0000EFBE, 1'b0, "R7 two reply bytes");

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule